// File: doc/BRIEF.md
# CRT Display Timing Generator with Polled Status Byte

This block turns a character clock into the raster timing of a cathode-ray display. A horizontal counter steps once per character clock and wraps at the line total. A vertical counter steps once per line and wraps at the frame total. From the two counts the block forms a display-enable window, a horizontal sync pulse and a vertical sync pulse. The enable output can be delayed by zero to three character clocks. This skew lines it up with a downstream pixel pipeline.

Software finds its place in the frame by polling a read-only status byte. Bit 0 is the live inverse of the skewed display enable. On an active line it toggles once per line, during the horizontal non-display portion. After the last displayed row it stays high through bottom overscan, blanking and retrace, until the next frame begins. Bit 3 carries vertical sync, registered once per character clock. Software counts the bit 0 toggles to count scanlines and watches bit 3 to find retrace.

The byte is driven only while the read strobe is high. Reading it never disturbs the timing. With the default parameters the block gives 400 active lines of 80 characters, which is 640 pixels at eight pixels per character.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset both counters are zero. The horizontal count runs 0 to H_TOTAL-1 and then wraps to 0. The vertical count advances by one on each horizontal wrap and runs 0 to V_TOTAL-1.
- R2: The unskewed enable is high exactly when the horizontal count is below H_DISP and the vertical count is below V_DISP. On every active line it is therefore low for the H_DISP to H_TOTAL-1 portion.
- R3: From row V_DISP to row V_TOTAL-1 the enable is low on every character clock. This covers overscan, blanking and retrace, up to the frame restart.
- R4: `de_o` equals the unskewed enable delayed by `skew_sel` character clocks (0 to 3). It is low during the first `skew_sel` clocks after reset, so at frame start it rises `skew_sel` clocks after count (0,0).
- R5: `hsync_o` is high exactly when the horizontal count lies in [H_SYNC_START, H_SYNC_START+H_SYNC_WIDTH).
- R6: `vsync_o` is high exactly when the vertical count lies in [V_SYNC_START, V_SYNC_START+V_SYNC_WIDTH). V_SYNC_START must be greater than V_DISP.
- R7: While `rd_stb` is high, `status_o[0]` is the inverse of `de_o` on the same cycle, with no register between them.
- R8: While `rd_stb` is high, `status_o[3]` equals the value `vsync_o` had one character clock earlier. It reads 0 on the first clock after reset.
- R9: `status_o` bits 1, 2 and 4 to 7 read 0, and the whole byte is 0 while `rd_stb` is low. Reads have no effect on counters, syncs or enable.
- R10: The default parameters give 400 enable rising edges and 32000 enabled character clocks per 44900-clock frame (100 x 449).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Asynchronous active-high reset |
| skew_sel | input | SKEW_W | Display-enable delay in character clocks |
| rd_stb | input | 1 | Status read strobe; status byte driven while high |
| de_o | output | 1 | Skewed display enable |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| status_o | output | 8 | Status byte: bit 0 = not enable, bit 3 = registered vsync |

## Verification
The bench sweeps several whole frames of a tiny raster for every skew value and compares every output on every clock against a model built from the modular cycle count. These sweeps catch three faults. An enable that stays high into the bottom rows would show up as extra scanlines in the blanking region. A skew tap taken one stage off would shift every enable edge by a clock. A status bit 3 that passes vsync straight through, with no register, would lead the expected value by a clock. The read strobe toggles throughout the sweeps, so a read that gated or disturbed the timing would also show. A final pass runs a default-sized instance for a whole frame and counts its enabled lines and clocks, which exposes an off-by-one in the totals.

// File: rtl/crt_pkg.sv
package crt_pkg;
  // true when val falls inside [start, start+width)
  function automatic logic in_span(input int val, input int start, input int width);
    return (val >= start) && (val < start + width);
  endfunction

  // active-area test against displayed limits
  function automatic logic in_active(input int h, input int v, input int h_disp, input int v_disp);
    return (h < h_disp) && (v < v_disp);
  endfunction
endpackage

// File: rtl/crt_wrap_counter.sv
module crt_wrap_counter #(
  parameter int TOTAL = 100,
  localparam int W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (int'(cnt) == TOTAL - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/crt_skew_delay.sv
module crt_skew_delay #(
  parameter int SKEW_W = 2,
  localparam int MAX_SKEW = (1 << SKEW_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SKEW_W-1:0] sel,
  input  logic              din,
  output logic              dout
);
  logic [MAX_SKEW:0] taps;
  assign taps[0] = din;

  for (genvar i = 1; i <= MAX_SKEW; i++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) taps[i] <= 1'b0;
      else     taps[i] <= taps[i-1];
    end
  end

  assign dout = taps[sel];
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int H_TOTAL      = 100,
  parameter int H_DISP       = 80,
  parameter int H_SYNC_START = 84,
  parameter int H_SYNC_WIDTH = 12,
  parameter int V_TOTAL      = 449,
  parameter int V_DISP       = 400,
  parameter int V_SYNC_START = 412,
  parameter int V_SYNC_WIDTH = 2,
  parameter int SKEW_W       = 2,
  localparam int HW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1,
  localparam int VW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SKEW_W-1:0] skew_sel,
  input  logic              rd_stb,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [7:0]        status_o
);
  import crt_pkg::*;

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap;
  logic          v_wrap;
  logic          de_raw;
  logic          vs_latch;

  crt_wrap_counter #(.TOTAL(H_TOTAL)) u_hcnt (
    .clk(clk), .rst(rst), .step(1'b1), .cnt(h_cnt), .wrap(h_wrap)
  );

  crt_wrap_counter #(.TOTAL(V_TOTAL)) u_vcnt (
    .clk(clk), .rst(rst), .step(h_wrap), .cnt(v_cnt), .wrap(v_wrap)
  );

  assign de_raw  = in_active(int'(h_cnt), int'(v_cnt), H_DISP, V_DISP);
  assign hsync_o = in_span(int'(h_cnt), H_SYNC_START, H_SYNC_WIDTH);
  assign vsync_o = in_span(int'(v_cnt), V_SYNC_START, V_SYNC_WIDTH);

  crt_skew_delay #(.SKEW_W(SKEW_W)) u_skew (
    .clk(clk), .rst(rst), .sel(skew_sel), .din(de_raw), .dout(de_o)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) vs_latch <= 1'b0;
    else     vs_latch <= vsync_o;
  end

  assign status_o = rd_stb ? {4'b0000, vs_latch, 2'b00, ~de_o} : 8'h00;
endmodule

// File: rtl/crt_checks.sv
module crt_checks #(
  parameter int H_TOTAL      = 100,
  parameter int H_DISP       = 80,
  parameter int H_SYNC_START = 84,
  parameter int V_TOTAL      = 449,
  parameter int V_DISP       = 400,
  parameter int V_SYNC_START = 412,
  parameter int SKEW_W       = 2,
  parameter int HW           = 7,
  parameter int VW           = 9,
  localparam int MAX_SKEW = (1 << SKEW_W) - 1
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          de_raw,
  input logic          de_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          rd_stb,
  input logic [7:0]    status_o
);
  initial p_cfg_gap_r6: assert (V_SYNC_START > V_DISP);

  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_cnt) == H_TOTAL - 1) |=> (h_cnt == '0) &&
      (int'(v_cnt) == ((int'($past(v_cnt)) == V_TOTAL - 1) ? 0 : int'($past(v_cnt)) + 1)));

  p_hrange_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_cnt) < H_TOTAL) && (int'(v_cnt) < V_TOTAL));

  p_hblank_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(h_cnt) >= H_DISP) |-> !de_raw);

  p_vblank_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(v_cnt) >= V_DISP && int'(h_cnt) > MAX_SKEW) |-> !de_o);

  p_hsync_r5: assert property (@(posedge clk) disable iff (rst)
    hsync_o |-> (int'(h_cnt) >= H_SYNC_START));

  p_vsync_gap_r6: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> (int'(v_cnt) > V_DISP) && !de_raw);

  p_bit0_live_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (status_o[0] != de_o));

  p_bit3_lag_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!rd_stb || (status_o[3] == $past(vsync_o))));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |-> (status_o == 8'h00));

  p_spare_bits_r9: assert property (@(posedge clk) disable iff (rst)
    (status_o[7:4] == 4'h0) && (status_o[2:1] == 2'b00));
endmodule

bind crt_timing_gen crt_checks #(
  .H_TOTAL(H_TOTAL), .H_DISP(H_DISP), .H_SYNC_START(H_SYNC_START),
  .V_TOTAL(V_TOTAL), .V_DISP(V_DISP), .V_SYNC_START(V_SYNC_START),
  .SKEW_W(SKEW_W), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .de_raw(de_raw),
  .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .rd_stb(rd_stb),
  .status_o(status_o)
);

// File: tb/tb_crt_timing_gen.sv
module tb_crt_timing_gen;
  localparam int HT = 8, HD = 5, HSS = 6, HSW = 1;
  localparam int VT = 10, VD = 4, VSS = 6, VSW = 2;
  localparam int FRAME = HT * VT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] skew_sel = 2'd0;
  logic       rd_stb = 1'b0;
  logic       de_o, hsync_o, vsync_o;
  logic [7:0] status_o;
  logic       de_d, hs_d, vs_d;
  logic [7:0] st_d;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  crt_timing_gen #(
    .H_TOTAL(HT), .H_DISP(HD), .H_SYNC_START(HSS), .H_SYNC_WIDTH(HSW),
    .V_TOTAL(VT), .V_DISP(VD), .V_SYNC_START(VSS), .V_SYNC_WIDTH(VSW)
  ) dut (
    .clk(clk), .rst(rst), .skew_sel(skew_sel), .rd_stb(rd_stb),
    .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .status_o(status_o)
  );

  crt_timing_gen dut_def (
    .clk(clk), .rst(rst), .skew_sel(skew_sel), .rd_stb(rd_stb),
    .de_o(de_d), .hsync_o(hs_d), .vsync_o(vs_d), .status_o(st_d)
  );

  function automatic int hpos(int n); return n % HT; endfunction
  function automatic int vpos(int n); return (n / HT) % VT; endfunction
  function automatic bit raw_en(int n);
    return (hpos(n) < HD) && (vpos(n) < VD);
  endfunction
  function automatic bit exp_de(int n, int s);
    return (n >= s) ? raw_en(n - s) : 1'b0;
  endfunction
  function automatic bit exp_hs(int n);
    return (hpos(n) >= HSS) && (hpos(n) < HSS + HSW);
  endfunction
  function automatic bit exp_vs(int n);
    return (vpos(n) >= VSS) && (vpos(n) < VSS + VSW);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    rst = 1'b1;
    skew_sel = 2'(s);
    rd_stb = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 3; s >= 0; s--) begin
      do_reset(s);
      // reset state R1 and R4: counters at zero, enable held off when skewed
      #1;
      check("R1 reset hsync", int'(hsync_o), 0);
      check("R4 reset de", int'(de_o), int'(exp_de(0, s)));
      for (int n = 0; n < 3 * FRAME + 5; n++) begin
        bit ed, eh, ev, ev_prev;
        logic [7:0] es;
        rd_stb = (n % 3) != 2;
        #1;
        ed = exp_de(n, s);
        eh = exp_hs(n);
        ev = exp_vs(n);
        ev_prev = (n >= 1) ? exp_vs(n - 1) : 1'b0;
        es = rd_stb ? {4'h0, ev_prev, 2'b00, ~ed} : 8'h00;
        if (vpos(n) >= VD && hpos(n) > 3)
          check("R3 bottom rows enable low", int'(de_o), 0);
        else if (s == 0)
          check("R2 enable window", int'(de_o), int'(ed));
        else
          check("R4 skewed enable", int'(de_o), int'(ed));
        check("R5 hsync", int'(hsync_o), int'(eh));
        check("R6 vsync", int'(vsync_o), int'(ev));
        if (rd_stb) begin
          check("R7 status bit0", int'(status_o[0]), int'(es[0]));
          check("R8 status bit3", int'(status_o[3]), int'(es[3]));
        end
        check("R9 status byte", int'(status_o), int'(es));
        @(negedge clk);
      end
    end

    // R10: default raster over one full frame, skew 0
    do_reset(0);
    begin
      int de_cnt = 0;
      int rises = 0;
      bit prev = 1'b0;
      for (int n = 0; n < 44900; n++) begin
        rd_stb = n[0];
        #1;
        if (de_d) de_cnt++;
        if (de_d && !prev) rises++;
        prev = de_d;
        @(negedge clk);
      end
      check("R10 default enabled clocks", de_cnt, 32000);
      check("R10 default scanlines", rises, 400);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule